// File: doc/BRIEF.md
# Dual Peripheral Parallel I/O Port

This block gives a host two independent 7-bit peripheral ports. Every bit of a port can be an input or an output. Byte-wide host registers set, for each port, the bit directions, the output data, who owns the pads, and whether bit 6 is handed to an interrupt/latch line. The block drives a pad output value and a pad output enable per bit. It brings the pad inputs in through a two-flop synchronizer. When bit 6's latch function is on, it routes that bit to a dedicated latch/interrupt output.

Each port has an ownership bit. While it is 0 the port is controller-managed: the pad value and enable come from alternate controller inputs, and host data/direction writes still land in the registers but do not reach the pads. While it is 1 the host drives the pads directly from its data and direction registers. The host data read always merges two sources: input bits show the synchronized pin, and output bits show the value last written.

Top module: `dual_pio_port`

## Requirements
- R1: After reset every port has all direction bits 0 (input), ownership 0 (controller-managed), latch function off, and data register 0. While in reset, pad_oe equals ctl_oe and pad_out equals ctl_out masked by ctl_oe.
- R2: Register addresses are {kind[1:0], port}, with port in addr[0] (0 = port A, 1 = port B). Kind 0 is data, 1 is direction, 2 is ownership and 3 is latch enable. Data and direction use wdata[6:0]; ownership and latch enable use wdata[0]. rdata[7] always reads 0.
- R3: A data read returns, bit by bit, the written data where the host direction bit is 1 (output), and the synchronized pin where it is 0 (input).
- R4: A pin change becomes visible on the data read, and on the latch output, after exactly two rising clock edges.
- R5: With ownership 1, pad_oe equals the direction register and pad_out equals data on output bits and 0 on input bits. A data write therefore changes pad_out only on output bits.
- R6: Reads of the direction, ownership and latch-enable addresses return 0.
- R7: With ownership 0, pad_oe follows ctl_oe and pad_out is ctl_out masked by the enable. Host data and direction writes do not reach the pads.
- R8: host_own[p] reflects the ownership bit of port p.
- R9: With latch enable 1, latch_out[p] is the synchronized bit 6 of port p. With latch enable 0, latch_out[p] is 0.
- R10: With latch enable 1, the bit 6 output enable is forced to 0 in either ownership mode, and bit 6 reads the pin even if its direction bit is 1.
- R11: A write to one port leaves the other port's pads, reads and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register address {kind, port} |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for addr (combinational) |
| pad_in | input | 14 | Pad inputs, port A in [6:0], port B in [13:7] |
| pad_out | output | 14 | Pad drive values |
| pad_oe | output | 14 | Pad output enables |
| ctl_out | input | 14 | Controller alternate drive values |
| ctl_oe | input | 14 | Controller alternate output enables |
| host_own | output | 2 | Ownership bit per port (1 = host direct) |
| latch_out | output | 2 | Bit-6 interrupt/latch line per port |

## Verification
The interesting overlap is a host write to a port's data register in the same clock edge that the synchronizer's second stage takes a new pin value for that port's input bits. The bench changes the pad one edge ahead, so that the second synchronizer stage and the data write land on the same edge. It then reads the port one half-cycle later. The read must merge the newly written output bits with the newly arrived pin bits, pad_out must show only the written output bits, and the other port must stay untouched.

// File: rtl/dual_pio_port.sv
module dual_pio_port #(
  parameter int PW = 7,
  parameter int NP = 2,
  parameter int DW = 8,
  parameter int LATCH_BIT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [((NP>1)?$clog2(NP):1)+1:0] addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [NP*PW-1:0]      pad_in,
  output logic [NP*PW-1:0]      pad_out,
  output logic [NP*PW-1:0]      pad_oe,
  input  logic [NP*PW-1:0]      ctl_out,
  input  logic [NP*PW-1:0]      ctl_oe,
  output logic [NP-1:0]         host_own,
  output logic [NP-1:0]         latch_out
);
  localparam int PIW = (NP > 1) ? $clog2(NP) : 1;
  localparam int AW = PIW + 2;
  localparam logic [1:0] K_DATA = 2'd0;
  localparam logic [1:0] K_DIR  = 2'd1;
  localparam logic [1:0] K_OWN  = 2'd2;
  localparam logic [1:0] K_LE   = 2'd3;
  localparam logic [PW-1:0] LMASK = PW'(1) << LATCH_BIT;

  wire [1:0]     kind = addr[AW-1:PIW];
  wire [PIW-1:0] pidx = addr[PIW-1:0];

  logic [PW-1:0] data_q [NP];
  logic [PW-1:0] dir_q  [NP];
  logic [PW-1:0] s1_q   [NP];
  logic [PW-1:0] s2_q   [NP];
  logic [PW-1:0] rd_val [NP];
  logic          own_q  [NP];
  logic          le_q   [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    wire hit = wr_en && (pidx == PIW'(p));
    wire [PW-1:0] le_m   = le_q[p] ? LMASK : '0;
    wire [PW-1:0] dir_ef = dir_q[p] & ~le_m;
    wire [PW-1:0] oe_ef  = (own_q[p] ? dir_q[p] : ctl_oe[p*PW +: PW]) & ~le_m;
    wire [PW-1:0] dv     = own_q[p] ? data_q[p] : ctl_out[p*PW +: PW];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[p] <= '0;
        dir_q[p]  <= '0;
        own_q[p]  <= 1'b0;
        le_q[p]   <= 1'b0;
        s1_q[p]   <= '0;
        s2_q[p]   <= '0;
      end else begin
        s1_q[p] <= pad_in[p*PW +: PW];
        s2_q[p] <= s1_q[p];
        if (hit && kind == K_DATA) data_q[p] <= wdata[PW-1:0];
        if (hit && kind == K_DIR)  dir_q[p]  <= wdata[PW-1:0];
        if (hit && kind == K_OWN)  own_q[p]  <= wdata[0];
        if (hit && kind == K_LE)   le_q[p]   <= wdata[0];
      end
    end

    assign pad_oe[p*PW +: PW]  = oe_ef;
    assign pad_out[p*PW +: PW] = dv & oe_ef;
    assign rd_val[p]   = (data_q[p] & dir_ef) | (s2_q[p] & ~dir_ef);
    assign host_own[p] = own_q[p];
    assign latch_out[p] = le_q[p] & s2_q[p][LATCH_BIT];

    assert_latch_blocks_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && kind == K_LE && wdata[0]) |=> !pad_oe[p*PW + LATCH_BIT]);

    assert_host_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && kind == K_DATA && own_q[p] && !le_q[p] && (&dir_q[p]))
        |=> pad_out[p*PW +: PW] == $past(wdata[PW-1:0]));

    assert_ctrl_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_q[p] && !le_q[p]) |-> pad_oe[p*PW +: PW] == ctl_oe[p*PW +: PW]);

    assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (le_q[p] && $past(le_q[p])) |-> latch_out[p] == $past(s1_q[p][LATCH_BIT]));

    assert_latch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !le_q[p] |-> !latch_out[p]);
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NP; p++)
      if (kind == K_DATA && pidx == PIW'(p))
        rdata = {{(DW-PW){1'b0}}, rd_val[p]};
  end

  assert_ctrl_regs_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != K_DATA) |-> rdata == '0);

  assert_top_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[DW-1]);
endmodule

// File: tb/dual_pio_port_tb.sv
`timescale 1ns/1ps
module dual_pio_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [13:0] pad_in = 0;
  logic [13:0] pad_out, pad_oe;
  logic [13:0] ctl_out = {7'h33, 7'h11};
  logic [13:0] ctl_oe  = {7'h1E, 7'h7F};
  logic [1:0]  host_own, latch_out;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dual_pio_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ctl_out(ctl_out), .ctl_oe(ctl_oe), .host_own(host_own), .latch_out(latch_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pad_oe in reset", 16'(pad_oe), 16'(ctl_oe));
    chk("R1 pad_out in reset", 16'(pad_out), 16'({7'h12, 7'h11}));
    @(negedge clk); rst_n = 1;
    edges(1);
    chk("R1 host_own", 16'(host_own), 16'h0);
    chk("R1 latch_out", 16'(latch_out), 16'h0);
    rd(3'd0, d); chk("R1 data A reset", 16'(d), 16'h0);
  endtask

  task automatic t_host_mode;
    logic [7:0] d;
    wr(3'd4, 8'h01); wr(3'd2, 8'h0F); wr(3'd0, 8'hFA);
    chk("R8 host_own A", 16'(host_own), 16'h1);
    chk("R5 pad_oe A", 16'(pad_oe[6:0]), 16'h0F);
    chk("R5 pad_out A only outputs", 16'(pad_out[6:0]), 16'h0A);
    pad_in[6:0] = 7'h55; edges(2);
    rd(3'd0, d); chk("R3 merged read A", 16'(d), 16'h5A);
    chk("R2 rdata bit7 zero", 16'(d[7]), 16'h0);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk); pad_in[6:0] = 7'h25;
    edges(1); rd(3'd0, d); chk("R4 one edge not yet", 16'(d), 16'h5A);
    edges(1); rd(3'd0, d); chk("R4 two edges visible", 16'(d), 16'h2A);
  endtask

  task automatic t_readzero;
    logic [7:0] d;
    for (int a = 2; a < 8; a++) begin
      rd(3'(a), d); chk("R6 control read zero", 16'(d), 16'h0);
    end
  endtask

  task automatic t_ctrl;
    wr(3'd3, 8'h7F); wr(3'd1, 8'h7F);
    chk("R7 pad_oe B controller", 16'(pad_oe[13:7]), 16'h1E);
    chk("R7 pad_out B controller", 16'(pad_out[13:7]), 16'h12);
    chk("R8 host_own B stays 0", 16'(host_own), 16'h1);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    wr(3'd2, 8'h4F); wr(3'd6, 8'h01);
    chk("R10 bit6 oe forced off", 16'(pad_oe[6:0]), 16'h0F);
    @(negedge clk); pad_in[6:0] = 7'h00; edges(2);
    chk("R9 latch low", 16'(latch_out), 16'h0);
    rd(3'd0, d); chk("R10 bit6 reads pin", 16'(d), 16'h0A);
    @(negedge clk); pad_in[6:0] = 7'h40; edges(2);
    chk("R9 latch follows pin", 16'(latch_out), 16'h1);
    rd(3'd0, d); chk("R10 bit6 pin high", 16'(d), 16'h4A);
    wr(3'd6, 8'h00);
    chk("R9 latch off gives 0", 16'(latch_out), 16'h0);
    chk("R10 oe restored", 16'(pad_oe[6:0]), 16'h4F);
    rd(3'd0, d); chk("R3 bit6 output reads written", 16'(d), 16'h4A);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    logic [13:7] ob, eb;
    wr(3'd2, 8'h0F);
    @(negedge clk); pad_in[6:0] = 7'h00; edges(2);
    ob = pad_out[13:7]; eb = pad_oe[13:7];
    @(negedge clk); pad_in[6:0] = 7'h30;
    @(negedge clk); wr_en = 1; addr = 3'd0; wdata = 8'h05;
    @(negedge clk); wr_en = 0;
    rd(3'd0, d); chk("R3 same-edge write and sync", 16'(d), 16'h35);
    chk("R5 pad_out after collision", 16'(pad_out[6:0]), 16'h05);
    chk("R11 port B pad_out untouched", 16'(pad_out[13:7]), 16'(ob));
    chk("R11 port B pad_oe untouched", 16'(pad_oe[13:7]), 16'(eb));
    rd(3'd1, d); chk("R11 port B read", 16'(d), 16'h7F);
  endtask

  initial begin
    fork
      begin
        edges(3);
        t_reset(); t_host_mode(); t_sync(); t_readzero();
        t_ctrl(); t_latch(); t_collision();
      end
      begin
        edges(5000);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule